// File: doc/BRIEF.md
# Pausible Local Clock Transfer Controller

This block stands in for a receiver island whose local clock can be halted so that a word from another clock domain can be handed over without a synchronizer. A free-running fast reference clock steps a phase timer. The timer produces a local clock level and a one-cycle clock-enable that marks each local rising edge. One or more senders each own a request/acknowledge pair and a data word. A sender asks for the local clock to stop. The block halts the clock in its low level and acknowledges. While the acknowledge is high, the input holding register follows that sender's data. When the sender drops its request, the block drops the acknowledge, keeps the captured word and restarts the clock with a full low phase. At the first local rising edge after that, it flags the word as valid for one local clock cycle.

Each phase ends in an exclusive choice between two outcomes: produce the next clock phase, or grant the pending pause. The choice never grants both. When several senders compete, a round-robin arbiter in front of that choice picks one.

The controller state machine has four states. ST_LOW and ST_HIGH are the running clock levels, ST_HALT is the stopped clock with the acknowledge raised, and ST_DROP is the stopped clock with the acknowledge removed. It has these transitions:
- At the end of a phase, with no pause granted: ST_LOW goes to ST_HIGH and ST_HIGH goes to ST_LOW. These are the tick transitions.
- At the end of a phase, with a pause granted: ST_LOW or ST_HIGH goes to ST_HALT. This is the pause transition.
- When the served request is seen low: ST_HALT goes to ST_DROP. This is the release transition.
- Always, one cycle later: ST_DROP goes to ST_LOW. This is the restart transition.

Top module: `pclk_xfer_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, lclk, lclk_en, snd_ack and rx_valid are 0 and rx_data is all zeros.
- R2: When no pause is involved, lclk stays high for exactly HALF_CYC reference cycles and low for exactly HALF_CYC reference cycles. lclk_en is high for one reference cycle, the last low cycle before each rising of lclk.
- R3: A pause is granted only when a phase ends. A request that arrives while lclk is high leaves that high phase at its full HALF_CYC length, and no acknowledge is ever high while lclk is high.
- R4: An acknowledge rises only with lclk low, and lclk stays low while it is high. From the cycle after the acknowledge is first seen, rx_data equals the acknowledged sender's data, lagging it by one cycle.
- R5: One cycle after the served sender's request is sampled low, its acknowledge falls. rx_data then keeps the word that was present on that sender's data slice when the request was sampled low.
- R6: After a pause, lclk stays low for the cycle in which the acknowledge falls plus a full HALF_CYC cycles before it rises, so no shortened phase appears.
- R7: At most one bit of snd_ack is high in any cycle.
- R8: Arbitration is round robin. After reset, source 0 has the highest priority. After source k is served, the search starts at source k+1, wrapping to 0.
- R9: Each completed transfer gives exactly one rx_valid pulse, one reference cycle wide, coincident with lclk_en at the first local rising edge after the transfer. A new pause is not granted before that edge.
- R10: Changes on snd_data while no acknowledge is high have no effect on rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_req | input | N_SRC | Per-sender request to stop the local clock |
| snd_data | input | N_SRC*DATA_W | Sender data words; sender i uses bits [i*DATA_W +: DATA_W] |
| snd_ack | output | N_SRC | Per-sender acknowledge: clock stopped, holding register open |
| lclk | output | 1 | Local clock level (1 in ST_HIGH) |
| lclk_en | output | 1 | One-cycle enable marking a local rising edge |
| rx_data | output | DATA_W | Holding register contents |
| rx_valid | output | 1 | One-cycle flag, the first local edge after a transfer |

## Verification
The bench builds the block with HALF_CYC=3, N_SRC=2 and DATA_W=8. A half period of three makes a request raised one cycle into a high phase fall strictly inside that phase, so the wait until the phase ends is visible. It also separates the restart low run of four cycles from the plain low run of three. Two senders are enough to raise truly simultaneous requests and to watch the round-robin pointer change which one is served first.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HIGH = 2'd1,
        ST_HALT = 2'd2,
        ST_DROP = 2'd3
    } pclk_state_e;

endpackage

// File: rtl/pclk_phase_timer.sv
module pclk_phase_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign phase_end = run && (cnt_q == LAST);

    always_ff @(posedge clk_ref) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pclk_rr_arb.sv
module pclk_rr_arb #(
    parameter int N_SRC = 2,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic             take,
    output logic [IW-1:0]    gnt_idx,
    output logic             any_req
);
    logic [IW-1:0] ptr_q;

    always_comb begin
        gnt_idx = '0;
        any_req = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[(int'(ptr_q) + i) % N_SRC]) begin
                gnt_idx = IW'((int'(ptr_q) + i) % N_SRC);
                any_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take) begin
            ptr_q <= (int'(gnt_idx) == N_SRC - 1) ? '0 : gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pclk_mutex.sv
module pclk_mutex (
    input  logic phase_end,
    input  logic want_pause,
    output logic tick,
    output logic pause
);
    always_comb begin
        tick  = 1'b0;
        pause = 1'b0;
        if (phase_end) begin
            if (want_pause) begin
                pause = 1'b1;
            end else begin
                tick = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pclk_xfer_ctrl.sv
module pclk_xfer_ctrl
    import pclk_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int N_SRC    = 2,
    parameter int DATA_W   = 8
) (
    input  logic                      clk_ref,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          snd_req,
    input  logic [N_SRC*DATA_W-1:0]   snd_data,
    output logic [N_SRC-1:0]          snd_ack,
    output logic                      lclk,
    output logic                      lclk_en,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      rx_valid
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    pclk_state_e         state_q, state_d;
    logic [IW-1:0]       gnt_q;
    logic [IW-1:0]       arb_idx;
    logic                arb_any;
    logic [DATA_W-1:0]   hold_q;
    logic                pend_q;
    logic                running;
    logic                phase_end;
    logic                tick;
    logic                pause;

    assign running = (state_q == ST_LOW) || (state_q == ST_HIGH);

    pclk_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .run       (running),
        .phase_end (phase_end)
    );

    pclk_rr_arb #(.N_SRC(N_SRC)) u_arb (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .req     (snd_req),
        .take    (pause),
        .gnt_idx (arb_idx),
        .any_req (arb_any)
    );

    pclk_mutex u_mutex (
        .phase_end  (phase_end),
        .want_pause (arb_any && !pend_q),
        .tick       (tick),
        .pause      (pause)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (pause)     state_d = ST_HALT;
                else if (tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (pause)     state_d = ST_HALT;
                else if (tick) state_d = ST_LOW;
            end
            ST_HALT: begin
                if (!snd_req[gnt_q]) state_d = ST_DROP;
            end
            ST_DROP: state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            gnt_q   <= '0;
            hold_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pause) begin
                gnt_q <= arb_idx;
            end
            if (state_q == ST_HALT) begin
                hold_q <= snd_data[int'(gnt_q)*DATA_W +: DATA_W];
            end
            if (state_q == ST_DROP) begin
                pend_q <= 1'b1;
            end else if (lclk_en) begin
                pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        snd_ack = '0;
        if (state_q == ST_HALT) begin
            snd_ack[gnt_q] = 1'b1;
        end
        lclk     = (state_q == ST_HIGH);
        lclk_en  = (state_q == ST_LOW) && tick;
        rx_valid = lclk_en && pend_q;
        rx_data  = hold_q;
    end
endmodule

// File: rtl/pclk_xfer_chk.sv
module pclk_xfer_chk #(
    parameter int N_SRC  = 2,
    parameter int DATA_W = 8
) (
    input logic                clk_ref,
    input logic                rst_n,
    input logic [N_SRC-1:0]    snd_req,
    input logic [N_SRC-1:0]    snd_ack,
    input logic                lclk,
    input logic                lclk_en,
    input logic [DATA_W-1:0]   rx_data,
    input logic                rx_valid
);
    a_r7_one_ack: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0(snd_ack));

    a_r3_ack_clock_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (|snd_ack) |-> !lclk);

    a_r2_en_then_high: assert property (@(posedge clk_ref) disable iff (!rst_n)
        lclk_en |=> lclk);

    a_r2_en_from_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
        lclk_en |-> !lclk);

    a_r5_ack_falls: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((|snd_ack) && !(|(snd_ack & snd_req))) |=> !(|snd_ack));

    a_r6_no_rise_after_drop: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(|snd_ack) |=> !lclk);

    a_r9_valid_on_edge: assert property (@(posedge clk_ref) disable iff (!rst_n)
        rx_valid |-> lclk_en);

    a_r9_valid_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r10_data_only_when_acked: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(rx_data) |-> $past(|snd_ack));
endmodule

bind pclk_xfer_ctrl pclk_xfer_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .snd_req  (snd_req),
    .snd_ack  (snd_ack),
    .lclk     (lclk),
    .lclk_en  (lclk_en),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
);

// File: tb/test_pclk_xfer_ctrl.sv
module test_pclk_xfer_ctrl;
    localparam int H  = 3;
    localparam int NS = 2;
    localparam int DW = 8;

    logic              clk_ref = 1'b0;
    logic              rst_n   = 1'b0;
    logic [NS-1:0]     snd_req = '0;
    logic [NS*DW-1:0]  snd_data = '0;
    logic [NS-1:0]     snd_ack;
    logic              lclk, lclk_en, rx_valid;
    logic [DW-1:0]     rx_data;

    int n_tests = 0;
    int n_fail  = 0;
    int n_xfer  = 0;
    int n_valid = 0;
    int first_idx;
    logic [DW-1:0] exp_q[$];

    always #2 clk_ref = ~clk_ref;

    pclk_xfer_ctrl #(.HALF_CYC(H), .N_SRC(NS), .DATA_W(DW)) i_pclk_xfer_ctrl (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .snd_req  (snd_req),
        .snd_data (snd_data),
        .snd_ack  (snd_ack),
        .lclk     (lclk),
        .lclk_en  (lclk_en),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // driver: one complete transfer for a source; pushes the expected word
    task automatic xfer(input int src, input logic [DW-1:0] d);
        @(negedge clk_ref);
        snd_data[src*DW +: DW] = d;
        snd_req[src] = 1'b1;
        while (!snd_ack[src]) @(negedge clk_ref);
        exp_q.push_back(d);
        n_xfer++;
        check(lclk == 1'b0, "R4", "clock low at ack", int'(lclk), 0);
        @(negedge clk_ref);
        check(rx_data == d, "R4", "register follows sender", int'(rx_data), int'(d));
        check(snd_ack[src] && lclk == 1'b0, "R4", "ack held, clock stopped",
              int'(snd_ack[src]), 1);
        snd_req[src] = 1'b0;
        @(negedge clk_ref);
        check(snd_ack[src] == 1'b0, "R5", "ack falls one cycle after release",
              int'(snd_ack[src]), 0);
        while (snd_ack[src]) @(negedge clk_ref);
        check(rx_data == d, "R5", "word captured", int'(rx_data), int'(d));
        snd_data[src*DW +: DW] = ~d;
    endtask

    // monitor / scoreboard
    initial begin
        logic prev_lclk = 1'b0;
        logic prev_ack  = 1'b0;
        logic prev_en   = 1'b0;
        logic prev_val  = 1'b0;
        logic paused    = 1'b0;
        logic started   = 1'b0;
        int   run_len   = 0;
        int   drop_cnt  = 0;
        forever begin
            @(negedge clk_ref);
            if (rst_n) begin
                if ((|snd_ack) && lclk)
                    check(1'b0, "R3", "ack while clock high", 1, 0);
                check($countones(snd_ack) <= 1, "R7", "acks at once",
                      $countones(snd_ack), 1);
                if (|snd_ack) paused = 1'b1;
                if (!(|snd_ack) && prev_ack) drop_cnt = 1;
                else if (!lclk && drop_cnt > 0) drop_cnt++;

                if (lclk && !prev_lclk) begin
                    check(prev_en, "R2", "enable before rise", int'(prev_en), 1);
                    if (started) begin
                        if (paused)
                            check(drop_cnt == H + 1, "R6", "low run after restart",
                                  drop_cnt, H + 1);
                        else
                            check(run_len == H, "R2", "low phase length", run_len, H);
                    end
                    started  = 1'b1;
                    paused   = 1'b0;
                    drop_cnt = 0;
                    run_len  = 1;
                end else if (!lclk && prev_lclk) begin
                    check(run_len == H, "R3", "high phase length", run_len, H);
                    run_len = 1;
                end else begin
                    run_len++;
                end

                if (rx_valid) begin
                    n_valid++;
                    check(lclk_en, "R9", "valid with enable", int'(lclk_en), 1);
                    check(!prev_val, "R9", "valid one cycle", int'(prev_val), 0);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", "valid without transfer", 1, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        check(rx_data == e, "R5", "delivered word", int'(rx_data), int'(e));
                    end
                end
                prev_lclk = lclk;
                prev_ack  = |snd_ack;
                prev_en   = lclk_en;
                prev_val  = rx_valid;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk_ref);
        check(1'b0, "WDOG", "run did not finish", 0, 1);
        summary();
    end

    task automatic race(input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input int exp_first);
        first_idx = -1;
        fork
            xfer(0, d0);
            xfer(1, d1);
            begin
                @(negedge clk_ref);
                while (!(|snd_ack)) @(negedge clk_ref);
                first_idx = snd_ack[1] ? 1 : 0;
            end
        join
        check(first_idx == exp_first, "R8", "round-robin winner", first_idx, exp_first);
    endtask

    initial begin
        repeat (3) @(negedge clk_ref);
        check(!lclk && !lclk_en && snd_ack == '0 && !rx_valid && rx_data == '0,
              "R1", "outputs in reset", int'(rx_data), 0);
        rst_n = 1'b1;
        @(negedge clk_ref);
        check(!lclk && snd_ack == '0 && !rx_valid && rx_data == '0,
              "R1", "outputs after reset", int'(lclk), 0);

        repeat (20) @(negedge clk_ref);
        xfer(0, 8'hA5);
        repeat (10) @(negedge clk_ref);

        // request raised in the middle of a high phase
        while (!lclk) @(negedge clk_ref);
        xfer(1, 8'h3C);
        repeat (10) @(negedge clk_ref);

        race(8'h11, 8'h22, 0);   // R8: pointer at 0 after serving source 1
        repeat (10) @(negedge clk_ref);
        xfer(0, 8'h5E);
        repeat (10) @(negedge clk_ref);
        race(8'h77, 8'h88, 1);   // R8: pointer at 1 after serving source 0
        repeat (20) @(negedge clk_ref);

        // R10: sender data changes without a request
        begin
            logic [DW-1:0] held;
            held = rx_data;
            for (int k = 0; k < 20; k++) begin
                snd_data = snd_data ^ 16'h5A3C ^ NS*DW'(k);
                @(negedge clk_ref);
                check(rx_data == held && snd_ack == '0 && !rx_valid, "R10",
                      "data change ignored", int'(rx_data), int'(held));
            end
        end

        repeat (20) @(negedge clk_ref);
        check(n_valid == n_xfer, "R9", "one valid per transfer", n_valid, n_xfer);
        check(exp_q.size() == 0, "R9", "no word left undelivered", exp_q.size(), 0);
        summary();
    end
endmodule